// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a simple register write/read port and a non-volatile storage array. Software selects an access mode, then either sends word-program requests on a dedicated program port or writes command registers that start erase operations. Each command is checked against the current mode and against the busy state. An accepted command is handed to the array as a one-cycle start pulse, with an operation code, an address and data. The block then stays busy for that operation's own duration.

While an operation runs, a ready flag reads 0 and a stall output is held high, so that requesters can hold off array reads. A command that arrives in the wrong mode or while busy is dropped, and it sets a sticky error flag that is cleared when it is read. A program request that is not a full, word-aligned 32-bit access raises a one-cycle fault pulse instead.

Top module: `flash_cmd_seq`

## Requirements
- R1: The mode register is at offset 0x504, with a 2-bit field in bits [1:0]: 0 means read-only, 1 means program-enabled and 2 means erase-enabled. Its reset value is 0. A write of 3 is ignored and leaves the previous mode in place. The field reads back at the same offset.
- R2: The status register at offset 0x400 has bit 0 set to 1 when idle and 0 while an operation is in progress. It resets to 1. The `ready` output mirrors it. The `stall` output is high for exactly the busy period, and for no cycle outside it.
- R3: A full-word, word-aligned program request is accepted only in mode 1 while idle. It produces operation code 1 with the request's address and data. It keeps the block busy for T_WRITE cycles.
- R4: A write to offset 0x508, or to its alias 0x510, starts a page erase only in mode 2 while idle. It produces code 2 with the written address rounded down to a PAGE_BYTES boundary. It is busy for T_PAGE cycles.
- R5: A write to 0x50C with bit 0 set starts a whole-array erase, which covers the code and user areas, in mode 2. It produces code 3 with address 0 and is busy for T_ALL cycles. A write with bit 0 clear has no effect and raises no error.
- R6: A write to 0x514 with bit 0 set starts a user-area erase in mode 2. It produces code 4 with address 0 and is busy for T_PAGE cycles. A write with bit 0 clear has no effect and raises no error.
- R7: The partial-erase length register is at 0x51C: 7 bits, reset value 10, readable. A write to 0x518 in mode 2 starts a partial page erase. It produces code 5 with the page-rounded address and is busy for max(length,1)*PART_UNIT cycles.
- R8: A program request with byte enables other than 4'hF, or with address bits [1:0] not zero, starts nothing. It raises `prog_fault` for exactly one cycle, in the cycle after the request, and does not set the error flag.
- R9: Some commands are rejected and set a sticky error, read at offset 0x404 bit 0 (reset 0): those in a disallowed mode, those that arrive while busy, and a program request in the same cycle as any erase-command write. A read of 0x404 clears the flag after returning it, and a new rejection in that same cycle takes priority over the clear.
- R10: `arr_start` pulses for one cycle, in the cycle after acceptance. `arr_op` holds the operation code for the whole busy period and is 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_valid | input | 1 | Register read strobe (clears error on 0x404) |
| rd_addr | input | 12 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| prog_valid | input | 1 | Program request strobe |
| prog_addr | input | 32 | Program byte address |
| prog_data | input | 32 | Program word |
| prog_be | input | 4 | Program byte enables |
| prog_fault | output | 1 | One-cycle fault for a malformed program request |
| ready | output | 1 | High when idle |
| stall | output | 1 | High for the whole busy period |
| arr_start | output | 1 | One-cycle start pulse to the array |
| arr_op | output | 3 | Operation code, held while busy |
| arr_addr | output | 32 | Target address for the array |
| arr_wdata | output | 32 | Program word for the array |

## Verification
The hardest situations to reach are the collisions. One is a command that lands while another operation is still counting down. The other is a program request that arrives in the same cycle as an erase-command write. The bench reaches the first by issuing a second request one cycle after an accepted one. It reaches the second by driving both strobes in one cycle. In both cases it reads the sticky flag twice, to see it set and then cleared. A full sweep of every mode against every command kind, and of every address-low/byte-enable pair, covers the gating and fault paths. The partial-erase length sweep includes the zero value.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 12;

  typedef enum logic [1:0] {
    MODE_RO = 2'd0,
    MODE_WR = 2'd1,
    MODE_ER = 2'd2
  } acc_mode_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PROG = 3'd1,
    OP_PAGE = 3'd2,
    OP_ALL  = 3'd3,
    OP_USER = 3'd4,
    OP_PART = 3'd5
  } flash_op_e;

  localparam logic [OFS_W-1:0] OFS_READY    = 12'h400;
  localparam logic [OFS_W-1:0] OFS_ERR      = 12'h404;
  localparam logic [OFS_W-1:0] OFS_MODE     = 12'h504;
  localparam logic [OFS_W-1:0] OFS_PAGE     = 12'h508;
  localparam logic [OFS_W-1:0] OFS_ALL      = 12'h50C;
  localparam logic [OFS_W-1:0] OFS_PAGE_ALT = 12'h510;
  localparam logic [OFS_W-1:0] OFS_USER     = 12'h514;
  localparam logic [OFS_W-1:0] OFS_PART     = 12'h518;
  localparam logic [OFS_W-1:0] OFS_PCFG     = 12'h51C;

  // Busy length in cycles for one operation; never below 1.
  function automatic int unsigned op_cycles(flash_op_e op, int unsigned t_wr,
                                            int unsigned t_pg, int unsigned t_all,
                                            int unsigned units, int unsigned unit);
    int unsigned r;
    case (op)
      OP_PROG:          r = t_wr;
      OP_PAGE, OP_USER: r = t_pg;
      OP_ALL:           r = t_all;
      OP_PART:          r = ((units == 0) ? 1 : units) * unit;
      default:          r = 1;
    endcase
    return (r == 0) ? 1 : r;
  endfunction

  function automatic logic [ADDR_W-1:0] page_base(logic [ADDR_W-1:0] a,
                                                  int unsigned page_bytes);
    logic [ADDR_W-1:0] m;
    m = ADDR_W'(page_bytes) - 1'b1;
    return a & ~m;
  endfunction

  function automatic logic word_shape_ok(logic [1:0] lo, logic [3:0] be);
    return (lo == 2'b00) && (be == 4'hF);
  endfunction

endpackage

// File: rtl/flash_reg_decode.sv
module flash_reg_decode
  import flash_seq_pkg::*;
#(
  parameter int CFG_W   = 7,
  parameter int CFG_RST = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [OFS_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output acc_mode_e           mode,
  output logic [CFG_W-1:0]    part_cfg,
  output logic                req_page,
  output logic                req_all,
  output logic                req_user,
  output logic                req_part,
  output logic [ADDR_W-1:0]   req_addr
);

  logic hit_mode, hit_pcfg, mode_legal;

  always_comb begin
    hit_mode   = wr_valid && (wr_addr == OFS_MODE);
    hit_pcfg   = wr_valid && (wr_addr == OFS_PCFG);
    mode_legal = (wr_data[1:0] != 2'd3);
    req_page   = wr_valid && ((wr_addr == OFS_PAGE) || (wr_addr == OFS_PAGE_ALT));
    req_all    = wr_valid && (wr_addr == OFS_ALL)  && wr_data[0];
    req_user   = wr_valid && (wr_addr == OFS_USER) && wr_data[0];
    req_part   = wr_valid && (wr_addr == OFS_PART);
    req_addr   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_RO;
      part_cfg <= CFG_W'(CFG_RST);
    end else begin
      if (hit_mode && mode_legal) mode <= acc_mode_e'(wr_data[1:0]);
      if (hit_pcfg) part_cfg <= wr_data[CFG_W-1:0];
    end
  end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/flash_err_track.sv
module flash_err_track (
  input  logic clk,
  input  logic rst_n,
  input  logic reject,
  input  logic misalign,
  input  logic clr,
  output logic err_flag,
  output logic fault
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      fault    <= 1'b0;
    end else begin
      if (reject)   err_flag <= 1'b1;
      else if (clr) err_flag <= 1'b0;
      fault <= misalign;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int T_WRITE    = 41,
  parameter int T_PAGE     = 850,
  parameter int T_ALL      = 1690,
  parameter int PART_UNIT  = 10,
  parameter int PAGE_BYTES = 1024,
  parameter int CFG_W      = 7,
  parameter int CFG_RST    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [11:0]       wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_valid,
  input  logic [11:0]       rd_addr,
  output logic [31:0]       rd_data,
  input  logic              prog_valid,
  input  logic [31:0]       prog_addr,
  input  logic [31:0]       prog_data,
  input  logic [3:0]        prog_be,
  output logic              prog_fault,
  output logic              ready,
  output logic              stall,
  output logic              arr_start,
  output logic [2:0]        arr_op,
  output logic [31:0]       arr_addr,
  output logic [31:0]       arr_wdata
);

  localparam int PART_MAX = ((1 << CFG_W) - 1) * PART_UNIT;
  localparam int MAX_A    = (T_ALL > T_PAGE) ? T_ALL : T_PAGE;
  localparam int MAX_B    = (T_WRITE > PART_MAX) ? T_WRITE : PART_MAX;
  localparam int MAX_DUR  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_DUR + 1);

  acc_mode_e           mode_q;
  logic [CFG_W-1:0]    part_cfg;
  logic                req_page, req_all, req_user, req_part;
  logic [ADDR_W-1:0]   req_addr;

  // Named events for the checker
  logic                reg_req, reg_accept, reg_reject;
  logic                shape_ok, prog_req, prog_accept, prog_reject;
  logic                misalign_evt, reject_evt, start_evt, err_clr;
  flash_op_e           op_sel;
  logic [CNT_W-1:0]    load_val;
  logic                busy, tmr_done, err_q;
  flash_op_e           op_q;

  flash_reg_decode #(.CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode(mode_q), .part_cfg(part_cfg),
    .req_page(req_page), .req_all(req_all), .req_user(req_user),
    .req_part(req_part), .req_addr(req_addr)
  );

  always_comb begin
    reg_req      = req_page | req_all | req_user | req_part;
    reg_accept   = reg_req && (mode_q == MODE_ER) && !busy;
    reg_reject   = reg_req && !reg_accept;
    shape_ok     = word_shape_ok(prog_addr[1:0], prog_be);
    prog_req     = prog_valid && shape_ok;
    prog_accept  = prog_req && (mode_q == MODE_WR) && !busy && !reg_req;
    prog_reject  = prog_req && !prog_accept;
    misalign_evt = prog_valid && !shape_ok;
    reject_evt   = reg_reject | prog_reject;
    start_evt    = reg_accept | prog_accept;
    err_clr      = rd_valid && (rd_addr == OFS_ERR);
  end

  always_comb begin
    if (req_page)      op_sel = OP_PAGE;
    else if (req_all)  op_sel = OP_ALL;
    else if (req_user) op_sel = OP_USER;
    else if (req_part) op_sel = OP_PART;
    else               op_sel = OP_PROG;
    load_val = CNT_W'(op_cycles(op_sel, T_WRITE, T_PAGE, T_ALL,
                                32'(part_cfg), PART_UNIT) - 1);
  end

  flash_op_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .load_val(load_val),
    .busy(busy), .done(tmr_done)
  );

  flash_err_track u_err (
    .clk(clk), .rst_n(rst_n), .reject(reject_evt), .misalign(misalign_evt),
    .clr(err_clr), .err_flag(err_q), .fault(prog_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_start <= 1'b0;
      op_q      <= OP_NONE;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      arr_start <= start_evt;
      if (start_evt) begin
        op_q <= op_sel;
        case (op_sel)
          OP_PROG:          arr_addr <= prog_addr;
          OP_PAGE, OP_PART: arr_addr <= page_base(req_addr, PAGE_BYTES);
          default:          arr_addr <= '0;
        endcase
        arr_wdata <= (op_sel == OP_PROG) ? prog_data : '0;
      end else if (tmr_done) begin
        op_q <= OP_NONE;
      end
    end
  end

  assign arr_op = op_q;
  assign ready  = ~busy;
  assign stall  = busy;

  always_comb begin
    case (rd_addr)
      OFS_READY: rd_data = {31'b0, ~busy};
      OFS_ERR:   rd_data = {31'b0, err_q};
      OFS_MODE:  rd_data = {30'b0, mode_q};
      OFS_PCFG:  rd_data = {{(32-CFG_W){1'b0}}, part_cfg};
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_seq_pkg::*;
#(
  parameter int T_WRITE   = 41,
  parameter int T_PAGE    = 850,
  parameter int T_ALL     = 1690,
  parameter int PART_UNIT = 10,
  parameter int CFG_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arr_start,
  input logic [2:0]       arr_op,
  input logic             stall,
  input logic             ready,
  input logic             prog_fault,
  input logic             prog_valid,
  input logic [3:0]       prog_be,
  input logic [1:0]       prog_addr_lo,
  input logic [1:0]       mode,
  input logic [CFG_W-1:0] part_cfg,
  input logic             reject_evt,
  input logic             err_flag
);

  logic [31:0] run_len, exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      exp_len <= '0;
    end else if (arr_start) begin
      run_len <= 32'd1;
      exp_len <= op_cycles(flash_op_e'(arr_op), T_WRITE, T_PAGE, T_ALL,
                           32'(part_cfg), PART_UNIT);
    end else if (stall) begin
      run_len <= run_len + 1'b1;
    end
  end

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (run_len == exp_len));

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> $past(ready));

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> (stall && (arr_op != 3'd0)));

  // R3
  prog_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_start && arr_op == 3'd1) |-> ($past(mode) == 2'd1));

  // R4
  erase_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_start && arr_op != 3'd1) |-> ($past(mode) == 2'd2));

  // R8
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fault |-> ($past(prog_valid) &&
                    ($past(prog_be) != 4'hF || $past(prog_addr_lo) != 2'd0)));

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(reject_evt));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .T_WRITE(T_WRITE), .T_PAGE(T_PAGE), .T_ALL(T_ALL),
  .PART_UNIT(PART_UNIT), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_start(arr_start), .arr_op(arr_op),
  .stall(stall), .ready(ready), .prog_fault(prog_fault),
  .prog_valid(prog_valid), .prog_be(prog_be), .prog_addr_lo(prog_addr[1:0]),
  .mode(mode_q), .part_cfg(part_cfg), .reject_evt(reject_evt),
  .err_flag(err_q)
);

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;

  localparam int TW = 3, TP = 7, TA = 13, PU = 2, PB = 64;

  logic        clk = 0, rst_n = 0;
  logic        wr_valid = 0, rd_valid = 0, prog_valid = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, prog_addr = 0, prog_data = 0;
  logic [3:0]  prog_be = 0;
  logic [31:0] rd_data, arr_addr, arr_wdata;
  logic        prog_fault, ready, stall, arr_start;
  logic [2:0]  arr_op;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.T_WRITE(TW), .T_PAGE(TP), .T_ALL(TA), .PART_UNIT(PU),
                  .PAGE_BYTES(PB)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .prog_valid(prog_valid), .prog_addr(prog_addr), .prog_data(prog_data),
    .prog_be(prog_be), .prog_fault(prog_fault), .ready(ready), .stall(stall),
    .arr_start(arr_start), .arr_op(arr_op), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    rd_valid = 1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic prog(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    prog_valid = 1; prog_addr = a; prog_data = d; prog_be = be;
    @(negedge clk);
    prog_valid = 0;
  endtask

  // kinds: 0 program, 1 page, 2 whole, 3 user, 4 partial, 5 page alias
  task automatic issue(input int kind, input logic [31:0] a);
    case (kind)
      0: prog(a, ~a, 4'hF);
      1: wr_reg(12'h508, a);
      2: wr_reg(12'h50C, 32'h1);
      3: wr_reg(12'h514, 32'h1);
      4: wr_reg(12'h518, a);
      default: wr_reg(12'h510, a);
    endcase
  endtask

  function automatic int exp_len(input int kind, input int cfg);
    case (kind)
      0: return TW;
      2: return TA;
      4: return ((cfg == 0) ? 1 : cfg) * PU;
      default: return TP;
    endcase
  endfunction

  function automatic logic [2:0] exp_code(input int kind);
    case (kind)
      0: return 3'd1;
      2: return 3'd3;
      3: return 3'd4;
      4: return 3'd5;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [31:0] exp_addr(input int kind, input logic [31:0] a);
    case (kind)
      0: return a;
      2, 3: return 32'h0;
      default: return a & ~(PB - 1);
    endcase
  endfunction

  task automatic observe(input string rq, input bit go, input logic [2:0] code,
                         input logic [31:0] ea, input int len);
    logic st; logic [2:0] op; logic [31:0] a; int n;
    st = arr_start; op = arr_op; a = arr_addr; n = 0;
    while (stall && n < 20000) begin n++; @(negedge clk); end
    check({rq, " start"}, st, go);
    if (go) begin
      check({rq, " code"}, op, code);
      check({rq, " addr"}, a, ea);
      check({rq, " busy length"}, n, len);
    end else check({rq, " busy length"}, n, 0);
    check({rq, " idle code (R10)"}, arr_op, 0);
    check({rq, " ready after (R2)"}, ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] a;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Reset state
    check("R2 reset ready", ready, 1);
    check("R2 reset stall", stall, 0);
    check("R10 reset code", arr_op, 0);
    rd_reg(12'h400, d); check("R2 reset status reg", d, 1);
    rd_reg(12'h504, d); check("R1 reset mode", d, 0);
    rd_reg(12'h51C, d); check("R7 reset length", d, 10);
    rd_reg(12'h404, d); check("R9 reset err", d, 0);

    // R1 mode encodings and ignored value 3
    for (int v = 0; v < 3; v++) begin
      wr_reg(12'h504, v);
      rd_reg(12'h504, d); check("R1 mode readback", d, v);
      wr_reg(12'h504, 32'h3);
      rd_reg(12'h504, d); check("R1 mode 3 ignored", d, v);
    end

    // Mode x command gating sweep (R3 R4 R5 R6 R7 R9)
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 6; k++) begin
        bit go;
        a = 32'h0000_1230 + 32'(k * 36 + m * 4);
        go = (k == 0) ? (m == 1) : (m == 2);
        wr_reg(12'h504, m);
        issue(k, a);
        if (k == 0 && go) check("R3 program data", arr_wdata, ~a);
        observe($sformatf("R3/R4/R5/R6/R7 mode %0d kind %0d", m, k), go,
                exp_code(k), exp_addr(k, a), exp_len(k, 10));
        rd_reg(12'h404, d); check("R9 err after gating", d, go ? 0 : 1);
        rd_reg(12'h404, d); check("R9 err cleared by read", d, 0);
      end
    end

    // R7 length sweep
    wr_reg(12'h504, 2);
    for (int c = 0; c < 8; c++) begin
      int cv;
      cv = (c == 7) ? 127 : c;
      wr_reg(12'h51C, cv);
      rd_reg(12'h51C, d); check("R7 length readback", d, cv);
      issue(4, 32'h0000_0ABC);
      observe("R7 partial sweep", 1, 3'd5, 32'h0000_0A80, exp_len(4, cv));
    end

    // R5 R6 bit 0 clear has no effect
    wr_reg(12'h50C, 32'hFFFF_FFFE);
    observe("R5 bit0 clear", 0, 0, 0, 0);
    wr_reg(12'h514, 32'h2);
    observe("R6 bit0 clear", 0, 0, 0, 0);
    rd_reg(12'h404, d); check("R5/R6 no error", d, 0);

    // R8 shape sweep
    wr_reg(12'h504, 1);
    for (int lo = 0; lo < 4; lo++) begin
      for (int b = 0; b < 16; b++) begin
        bit ok;
        ok = (lo == 0) && (b == 15);
        prog(32'h0000_0400 + 32'(lo), 32'h5A5A_0000 + 32'(b), 4'(b));
        check("R8 fault pulse", prog_fault, !ok);
        check("R8 start", arr_start, ok);
        @(negedge clk);
        check("R8 fault one cycle", prog_fault, 0);
        while (stall) @(negedge clk);
      end
    end
    rd_reg(12'h404, d); check("R8 no error from fault", d, 0);

    // R9 busy rejection
    prog(32'h0000_0800, 32'h1234_5678, 4'hF);
    check("R3 accepted", arr_start, 1);
    rd_reg(12'h400, d); check("R2 status busy", d, 0);
    prog(32'h0000_0804, 32'h1, 4'hF);
    check("R9 busy reject no start", arr_start, 0);
    while (stall) @(negedge clk);
    rd_reg(12'h404, d); check("R9 busy reject err", d, 1);
    rd_reg(12'h404, d); check("R9 err clear", d, 0);

    // R9 collision of program and erase-command write
    wr_valid = 1; wr_addr = 12'h508; wr_data = 32'h40;
    prog_valid = 1; prog_addr = 32'h0000_0900; prog_data = 0; prog_be = 4'hF;
    @(negedge clk);
    wr_valid = 0; prog_valid = 0;
    check("R9 collision no start", arr_start, 0);
    check("R9 collision stall", stall, 0);
    rd_reg(12'h404, d); check("R9 collision err", d, 1);

    // R9 set wins over clear in the same cycle
    rd_valid = 1; rd_addr = 12'h404;
    prog_valid = 1; prog_addr = 32'h0000_0904; prog_be = 4'hF;
    wr_valid = 1; wr_addr = 12'h50C; wr_data = 1;
    @(negedge clk);
    rd_valid = 0; prog_valid = 0; wr_valid = 0;
    rd_reg(12'h404, d); check("R9 set beats clear", d, 1);

    // R2 whole erase status while busy
    wr_reg(12'h504, 2);
    issue(2, 0);
    rd_reg(12'h400, d); check("R2 status during erase", d, 0);
    check("R2 stall during erase", stall, 1);
    while (stall) @(negedge clk);
    check("R2 ready after erase", ready, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule